// File: doc/BRIEF.md
# Cascade Acknowledge Vector Sequencer

This block runs the processor's interrupt-acknowledge handshake for an eight-input interrupt controller that may sit in a cascade of up to nine controllers. One master can serve up to eight slaves, which gives up to 64 vectored levels. The priority arbiter hands the block the winning level. The block then counts the acknowledge pulses and decides whether this controller, or a slave that it addresses over the three cascade lines, puts the vector bytes on the data bus.

In master role, the block drives the winning level onto the cascade lines when that input is wired to a slave controller. It drives the vector itself only when the input is a plain request line. In slave role, the block never drives the cascade lines. It compares the incoming identifier with its own and places its bytes on the bus only on a match.

The byte format depends on the processor mode latched when the first pulse starts. In 16-bit mode the first of two pulses returns nothing and the second returns a type byte. In 8-bit mode three pulses return a call opcode followed by a routine address. The acknowledge input is registered only in cycles where the active-low clock enable is low.

Top module: `cascade_ack_seq`

## Requirements
- R1: After reset, data_oe_o, cas_oe_o, data_o and cas_o are all zero and no sequence is in progress.
- R2: inta_ni is sampled only on clock edges where clk_en_ni is 0. Edges where clk_en_ni is 1 leave the sequence state, and therefore the outputs for a given set of inputs, unchanged.
- R3: grant_level_i and cpu16_i are latched on the edge that starts the first pulse of a sequence. Changes to them later in the same sequence have no effect on the bytes or on cas_o.
- R4: With cpu16_i=1 a sequence is two pulses long. Pulse 0 drives no data. Pulse 1 returns {vec_base_i[4:0], level[2:0]}, with the level in bits 2:0.
- R5: With cpu16_i=0 a sequence is three pulses long. The pulses return 8'hCD, then addr[7:0], then addr[15:8]. The address addr = call_base_i + level*8 when step8_i=1, or + level*4 when step8_i=0, taken modulo 2^16.
- R6: In master role, when slave_map_i[level] is 1, cas_oe_o is 1 with cas_o equal to the level from the first pulse until the end of the last pulse. In that case data_oe_o stays 0. Whenever cas_oe_o is 0, cas_o is 0.
- R7: In master role, when slave_map_i[level] is 0, the block drives its own bytes and cas_oe_o stays 0.
- R8: In slave role, cas_oe_o is always 0. data_oe_o is 1 on a byte-carrying pulse only while cas_i equals own_id_i.
- R9: data_oe_o is 1 only while a registered pulse is active, and data_o is zero whenever data_oe_o is 0.
- R10: After the last pulse ends the block returns to idle, and the next pulse starts a new sequence with a freshly latched level and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_ni | input | 1 | Sampling enable, active low |
| inta_ni | input | 1 | Interrupt acknowledge, active low |
| grant_level_i | input | 3 | Winning level from the arbiter |
| cpu16_i | input | 1 | 1 selects 16-bit processor format, 0 selects 8-bit |
| is_master_i | input | 1 | 1 selects master role, 0 selects slave role |
| slave_map_i | input | 8 | Master: inputs that are wired to slave controllers |
| own_id_i | input | 3 | Slave: own cascade identifier |
| cas_i | input | 3 | Cascade lines as seen by a slave |
| vec_base_i | input | 5 | Upper five bits of the 16-bit-mode type byte |
| call_base_i | input | 16 | Routine address base for 8-bit mode |
| step8_i | input | 1 | 8-bit mode address spacing: 1 selects 8, 0 selects 4 |
| cas_o | output | 3 | Cascade identifier driven by a master |
| cas_oe_o | output | 1 | Cascade line output enable |
| data_o | output | 8 | Vector byte |
| data_oe_o | output | 1 | Data bus output enable |

## Verification
The bench builds the block with its default widths: a 3-bit level, which gives eight inputs and eight slave identifiers, a 5-bit type base and a 16-bit routine address. Within those widths, random runs can reach every level, every slave-map pattern and both address spacings. Directed runs add an address base close to 0xFFFF so that the modulo wrap of the address sum is exercised. The bench also inserts gated cycles between pulses, changes the grant and the mode in the middle of a sequence, and drives slave identifiers that miss as well as ones that match.

// File: rtl/cas_ack_pkg.sv
package cas_ack_pkg;
  localparam int LVL_W   = 3;
  localparam int NUM_IN  = 1 << LVL_W;
  localparam int BYTE_W  = 8;
  localparam int BASE_W  = BYTE_W - LVL_W;
  localparam int ADDR_W  = 16;
  localparam int CNT_W   = 2;
  localparam logic [BYTE_W-1:0] CALL_OP = 8'hCD;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [CNT_W-1:0] idx_t;

  typedef struct packed {
    logic active;   // registered acknowledge is low
    logic in_seq;   // a sequence is open
    idx_t idx;      // index of current or next pulse
    lvl_t lvl;      // latched level
    logic mode16;   // latched processor mode
  } ack_state_t;
endpackage

// File: rtl/ack_pulse_tracker.sv
module ack_pulse_tracker
  import cas_ack_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clk_en_ni,
  input  logic       inta_ni,
  input  lvl_t       grant_level_i,
  input  logic       cpu16_i,
  output ack_state_t st_o
);
  logic inta_q;
  idx_t cnt_q;
  lvl_t lvl_q;
  logic mode_q;
  logic en, start, pulse_end;
  idx_t last_idx;

  assign en        = ~clk_en_ni;
  assign last_idx  = mode_q ? idx_t'(1) : idx_t'(2);
  assign start     = en & inta_q & ~inta_ni & (cnt_q == '0);
  assign pulse_end = en & ~inta_q & inta_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inta_q <= 1'b1;
      cnt_q  <= '0;
      lvl_q  <= '0;
      mode_q <= 1'b1;
    end else begin
      if (en) inta_q <= inta_ni;
      if (start) begin
        lvl_q  <= grant_level_i;
        mode_q <= cpu16_i;
      end
      if (pulse_end) cnt_q <= (cnt_q == last_idx) ? '0 : cnt_q + idx_t'(1);
    end
  end

  assign st_o.active = ~inta_q;
  assign st_o.in_seq = ~inta_q | (cnt_q != '0);
  assign st_o.idx    = cnt_q;
  assign st_o.lvl    = lvl_q;
  assign st_o.mode16 = mode_q;
endmodule

// File: rtl/vector_byte_mux.sv
module vector_byte_mux
  import cas_ack_pkg::*;
(
  input  ack_state_t        st_i,
  input  logic [BASE_W-1:0] vec_base_i,
  input  logic [ADDR_W-1:0] call_base_i,
  input  logic              step8_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              valid_o
);
  logic [ADDR_W-1:0] addr;

  assign addr = call_base_i + (ADDR_W'(st_i.lvl) << (step8_i ? 3 : 2));

  always_comb begin
    byte_o  = '0;
    valid_o = 1'b0;
    if (st_i.mode16) begin
      if (st_i.idx == idx_t'(1)) begin
        byte_o  = {vec_base_i, st_i.lvl};
        valid_o = 1'b1;
      end
    end else begin
      unique case (st_i.idx)
        idx_t'(0): begin byte_o = CALL_OP;                  valid_o = 1'b1; end
        idx_t'(1): begin byte_o = addr[BYTE_W-1:0];         valid_o = 1'b1; end
        idx_t'(2): begin byte_o = addr[ADDR_W-1:ADDR_W-BYTE_W]; valid_o = 1'b1; end
        default:   begin byte_o = '0;                       valid_o = 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/cas_role_unit.sv
module cas_role_unit
  import cas_ack_pkg::*;
(
  input  ack_state_t        st_i,
  input  logic              is_master_i,
  input  logic [NUM_IN-1:0] slave_map_i,
  input  lvl_t              own_id_i,
  input  lvl_t              cas_i,
  input  logic              byte_valid_i,
  output lvl_t              cas_o,
  output logic              cas_oe_o,
  output logic              drive_o
);
  logic lvl_is_slave, id_hit;

  assign lvl_is_slave = slave_map_i[st_i.lvl];
  assign id_hit       = (cas_i == own_id_i);
  assign cas_oe_o     = is_master_i & st_i.in_seq & lvl_is_slave;
  assign cas_o        = cas_oe_o ? st_i.lvl : '0;
  assign drive_o      = st_i.active & byte_valid_i &
                        (is_master_i ? ~lvl_is_slave : id_hit);
endmodule

// File: rtl/cascade_ack_seq.sv
module cascade_ack_seq
  import cas_ack_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_ni,
  input  logic              inta_ni,
  input  logic [LVL_W-1:0]  grant_level_i,
  input  logic              cpu16_i,
  input  logic              is_master_i,
  input  logic [NUM_IN-1:0] slave_map_i,
  input  logic [LVL_W-1:0]  own_id_i,
  input  logic [LVL_W-1:0]  cas_i,
  input  logic [BASE_W-1:0] vec_base_i,
  input  logic [ADDR_W-1:0] call_base_i,
  input  logic              step8_i,
  output logic [LVL_W-1:0]  cas_o,
  output logic              cas_oe_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              data_oe_o
);
  ack_state_t        st;
  logic [BYTE_W-1:0] vbyte;
  logic              vvalid, drive;

  ack_pulse_tracker u_trk (
    .clk_i, .rst_ni, .clk_en_ni, .inta_ni,
    .grant_level_i, .cpu16_i, .st_o(st)
  );

  vector_byte_mux u_mux (
    .st_i(st), .vec_base_i, .call_base_i, .step8_i,
    .byte_o(vbyte), .valid_o(vvalid)
  );

  cas_role_unit u_role (
    .st_i(st), .is_master_i, .slave_map_i, .own_id_i, .cas_i,
    .byte_valid_i(vvalid), .cas_o, .cas_oe_o, .drive_o(drive)
  );

  assign data_oe_o = drive;
  assign data_o    = drive ? vbyte : '0;
endmodule

// File: rtl/cascade_ack_seq_chk.sv
module cascade_ack_seq_chk
  import cas_ack_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clk_en_ni,
  input logic              is_master_i,
  input logic [LVL_W-1:0]  own_id_i,
  input logic [LVL_W-1:0]  cas_i,
  input logic              cas_oe_o,
  input logic [LVL_W-1:0]  cas_o,
  input logic              data_oe_o,
  input logic [BYTE_W-1:0] data_o,
  input ack_state_t        st_i
);
  AST_GATED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_ni |=> $stable(st_i)); // R2
  AST_LVL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i.in_seq && $past(st_i.in_seq)) |-> (st_i.lvl == $past(st_i.lvl))); // R3
  AST_FIRST16_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i.mode16 && st_i.idx == '0) |-> !data_oe_o); // R4
  AST_NO_FIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cas_oe_o && data_oe_o)); // R6
  AST_CAS_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_oe_o |-> (cas_o == '0)); // R6
  AST_SLAVE_NO_CAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_master_i |-> !cas_oe_o); // R8
  AST_SLAVE_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_master_i && data_oe_o) |-> (cas_i == own_id_i)); // R8
  AST_OE_IN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> st_i.active); // R9
  AST_DATA_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == '0)); // R9
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i.idx != 2'd3) && (!st_i.mode16 || st_i.idx <= 2'd1)); // R10
endmodule

bind cascade_ack_seq cascade_ack_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clk_en_ni(clk_en_ni),
  .is_master_i(is_master_i), .own_id_i(own_id_i), .cas_i(cas_i),
  .cas_oe_o(cas_oe_o), .cas_o(cas_o), .data_oe_o(data_oe_o),
  .data_o(data_o), .st_i(st)
);

// File: tb/cascade_ack_seq_bench.sv
module cascade_ack_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en_n = 1'b0;
  logic        inta_n = 1'b1;
  logic [2:0]  grant_level = '0;
  logic        cpu16 = 1'b1;
  logic        is_master = 1'b1;
  logic [7:0]  slave_map = '0;
  logic [2:0]  own_id = '0;
  logic [2:0]  cas_in = '0;
  logic [4:0]  vec_base = '0;
  logic [15:0] call_base = '0;
  logic        step8 = 1'b0;
  logic [2:0]  cas_o;
  logic        cas_oe;
  logic [7:0]  data_o;
  logic        data_oe;
  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cascade_ack_seq u_cascade_ack_seq (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_ni(clk_en_n), .inta_ni(inta_n),
    .grant_level_i(grant_level), .cpu16_i(cpu16), .is_master_i(is_master),
    .slave_map_i(slave_map), .own_id_i(own_id), .cas_i(cas_in),
    .vec_base_i(vec_base), .call_base_i(call_base), .step8_i(step8),
    .cas_o(cas_o), .cas_oe_o(cas_oe), .data_o(data_o), .data_oe_o(data_oe)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {valid, byte} of pulse k from the requirement formats
  function automatic logic [8:0] exp_byte(bit m16, int k, logic [2:0] lv,
                                          logic [4:0] vb, logic [15:0] cb, bit s8);
    logic [15:0] a;
    a = cb + (16'(lv) << (s8 ? 3 : 2));
    if (m16) return (k == 1) ? {1'b1, vb, lv} : 9'h0;
    case (k)
      0: return {1'b1, 8'hCD};
      1: return {1'b1, a[7:0]};
      default: return {1'b1, a[15:8]};
    endcase
  endfunction

  task automatic check_pulse(bit m16, int k, logic [2:0] lv, string note);
    logic [8:0] vb;
    bit drv, slv_lvl;
    string rtag, mtag;
    vb = exp_byte(m16, k, lv, vec_base, call_base, step8);
    slv_lvl = slave_map[lv];
    drv = vb[8] && (is_master ? !slv_lvl : (cas_in == own_id));
    rtag = is_master ? (slv_lvl ? "R6" : "R7") : "R8";
    mtag = m16 ? "R4" : "R5";
    chk({rtag, " oe ", note}, 16'(data_oe), 16'(drv));
    chk({mtag, "/R9 data ", note}, 16'(data_o), drv ? 16'(vb[7:0]) : 16'h0);
    chk({"R6 cas_oe ", note}, 16'(cas_oe), 16'(is_master && slv_lvl));
    chk({"R6 cas ", note}, 16'(cas_o), (is_master && slv_lvl) ? 16'(lv) : 16'h0);
  endtask

  task automatic run_seq(int gate_cyc, bit perturb);
    bit m16;
    logic [2:0] lv;
    int np;
    m16 = cpu16;
    lv = grant_level;
    np = m16 ? 2 : 3;
    for (int k = 0; k < np; k++) begin
      clk_en_n = 1'b0;
      inta_n = 1'b0;
      @(negedge clk);
      check_pulse(m16, k, lv, "pulse");
      if (k == 0 && perturb) begin
        grant_level = ~lv;  // R3: must be ignored mid-sequence
        cpu16 = ~m16;
      end
      if (k == 0) check_pulse(m16, k, lv, "R3 after change");
      clk_en_n = 1'b1;
      inta_n = 1'b1;
      for (int g = 0; g < gate_cyc; g++) begin
        @(negedge clk);
        check_pulse(m16, k, lv, "R2 gated");
      end
      clk_en_n = 1'b0;
      @(negedge clk);
      chk("R9 oe between pulses", 16'(data_oe), 16'h0);
      chk("R10 cas_oe after pulse", 16'(cas_oe),
          16'((k < np - 1) && is_master && slave_map[lv]));
    end
    @(negedge clk);
    chk("R10 idle after sequence", 16'({cas_oe, data_oe}), 16'h0);
  endtask

  task automatic rand_cfg();
    is_master = 1'($urandom_range(0, 1));
    slave_map = 8'($urandom());
    own_id = 3'($urandom());
    cas_in = ($urandom_range(0, 1) == 1) ? own_id : 3'($urandom());
    vec_base = 5'($urandom());
    call_base = 16'($urandom());
    step8 = 1'($urandom_range(0, 1));
    cpu16 = 1'($urandom_range(0, 1));
    grant_level = 3'($urandom());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 reset oe", 16'({cas_oe, data_oe}), 16'h0);
    chk("R1 reset buses", 16'({cas_o, data_o}), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", 16'({cas_oe, data_oe, data_o}), 16'h0);

    // R2: acknowledge held low while gated has no effect
    is_master = 1'b1; slave_map = 8'h00; cpu16 = 1'b0;
    clk_en_n = 1'b1; inta_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 gated ack ignored", 16'({cas_oe, data_oe, data_o}), 16'h0);
    inta_n = 1'b1; clk_en_n = 1'b0;
    @(negedge clk);

    // R5 wrap: 8-bit, level 7, step 8, base near top
    grant_level = 3'd7; step8 = 1'b1; call_base = 16'hFFF0;
    run_seq(1, 1'b1);
    // R5 step 4
    cpu16 = 1'b0; grant_level = 3'd5; step8 = 1'b0; call_base = 16'h1230;
    run_seq(0, 1'b0);
    // R4 master own vector
    cpu16 = 1'b1; grant_level = 3'd3; vec_base = 5'h11;
    run_seq(2, 1'b1);
    // R6 master with slave on level
    slave_map = 8'h08; cpu16 = 1'b0; grant_level = 3'd3;
    run_seq(1, 1'b0);
    // R8 slave match and miss
    is_master = 1'b0; own_id = 3'd2; cas_in = 3'd2; cpu16 = 1'b1; vec_base = 5'h1F;
    grant_level = 3'd6;
    run_seq(1, 1'b0);
    cas_in = 3'd5; cpu16 = 1'b0;
    run_seq(0, 1'b1);

    for (int n = 0; n < 80; n++) begin
      rand_cfg();
      run_seq($urandom_range(0, 2), 1'($urandom_range(0, 1)));
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule